// File: doc/BRIEF.md
# Holdover Exit Frequency Ramp Generator

When a clock synthesizer leaves holdover, or moves from one input clock to another, a sudden jump in its frequency control word upsets whatever is clocked downstream. This block avoids the jump. It moves the control word in a straight line from the value held during holdover to the new target value, at a rate chosen by software. The same block serves both uses: holdover exit and ramped switching between inputs.

A start pulse captures four things: the holdover word, the target word, a 3-bit step-size code that sets how much each step changes the word, and a 3-bit interval code that sets how many cycles pass between steps. The block takes the difference between the two words at that moment, and its sign decides whether the word counts up or down. The word then moves by one step per interval. The last step is cut short so that the word lands exactly on the target and never passes it. A busy flag is high during the ramp, and a one-cycle done pulse marks the cycle in which the target is reached. When the bypass bit is set, or the two words are equal, the word goes straight to the target. In that case the exit-bandwidth path that follows the block absorbs the change.

Top module: `holdoverRampGen`

## Requirements
- R1: While reset is held and on the first cycle after it, `freqWord` is 0, `busy` is 0 and `done` is 0.
- R2: A start with `bypass`=0 and `holdWord`≠`targetWord` makes `busy` 1 and `freqWord` equal to `holdWord` one cycle later.
- R3: During a ramp, `freqWord` changes only once every 2^`ivlCode` cycles. Each change is a step of 2^(2·`stepCode`) LSBs. The word counts up when the target captured at start is above the holdover word, and down when it is below.
- R4: The final step is clamped, so `freqWord` never passes the target. It equals the target exactly ceil(|target−hold| / step) × interval cycles after the start edge.
- R5: `done` is high for exactly one cycle, in the cycle where `freqWord` first equals the target. `busy` is 0 in that same cycle.
- R6: A start with `bypass`=1 sets `freqWord` to `targetWord` one cycle later, with `done` 1 and `busy` 0 for that cycle. `busy` never goes high.
- R7: A start with `holdWord`=`targetWord` and `bypass`=0 completes in the same way as R6, with no ramp.
- R8: A start during a ramp abandons it and begins a new ramp from the new `holdWord`, with the new codes.
- R9: While idle and without a start, changes on `holdWord`, `targetWord` and the codes leave `freqWord` unchanged.
- R10: Changes on `stepCode` and `ivlCode` during a ramp have no effect. The values captured at start are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a ramp or jump (one-cycle pulse) |
| holdWord | input | WORD_W | Frequency word held during holdover |
| targetWord | input | WORD_W | Frequency word to reach |
| stepCode | input | STEP_CODE_W | Step size code, step = 2^(STEP_SHIFT·code) |
| ivlCode | input | IVL_CODE_W | Interval code, interval = 2^code cycles |
| bypass | input | 1 | 1: jump to target without ramping |
| freqWord | output | WORD_W | Running frequency control word |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse when the target is reached |

## Verification
Every result appears one register stage after the edge that causes it. The holdover word or the target shows on `freqWord` one cycle after the start edge. The k-th step shows k·interval cycles after that edge, and `done` rises in the same cycle as the final step. The bench drives inputs on the falling edge and compares at each following falling edge. Its expected word for cycle m after start is hold ± min(floor(m/interval)·step, |diff|), so every cycle of a ramp is checked against that arithmetic model. The bench sweeps all step codes, four interval codes, both directions, clamped and exact final steps, words at both ends of the range, bypass, zero difference, a restart during a ramp, and idle stability.

// File: rtl/rampPkg.sv
package rampPkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;    // capture hold/target, start a ramp
    logic jump;    // go straight to target
    logic stepEn;  // apply one step (clamped at the end)
  } rampCmdT;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } rampStateT;
endpackage

// File: rtl/rampDatapath.sv
module rampDatapath
  import rampPkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int STEP_CODE_W = 3,
  parameter int STEP_SHIFT  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rampCmdT                cmd,
  input  logic [WORD_W-1:0]      holdWord,
  input  logic [WORD_W-1:0]      targetWord,
  input  logic [STEP_CODE_W-1:0] stepCode,
  output logic [WORD_W-1:0]      freqWord,
  output logic [WORD_W-1:0]      targetLatched,
  output logic                   dirDown,
  output logic                   zeroDiff,
  output logic                   lastStep
);
  localparam int SHIFT_W = STEP_CODE_W + $clog2(STEP_SHIFT + 1);

  logic [STEP_CODE_W-1:0] stepCodeReg;
  logic [WORD_W-1:0]      remaining;
  logic [WORD_W-1:0]      stepSize;
  logic [SHIFT_W-1:0]     shiftAmt;
  logic [WORD_W-1:0]      absDiff;

  assign shiftAmt = SHIFT_W'(stepCodeReg) * SHIFT_W'(STEP_SHIFT);
  assign stepSize = {{(WORD_W-1){1'b0}}, 1'b1} << shiftAmt;
  assign zeroDiff = (holdWord == targetWord);
  assign absDiff  = (targetWord < holdWord) ? (holdWord - targetWord)
                                            : (targetWord - holdWord);
  assign lastStep = (remaining <= stepSize);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqWord      <= '0;
      targetLatched <= '0;
      remaining     <= '0;
      dirDown       <= 1'b0;
      stepCodeReg   <= '0;
    end else if (cmd.load) begin
      freqWord      <= holdWord;
      targetLatched <= targetWord;
      remaining     <= absDiff;
      dirDown       <= (targetWord < holdWord);
      stepCodeReg   <= stepCode;
    end else if (cmd.jump) begin
      freqWord      <= targetWord;
      targetLatched <= targetWord;
      remaining     <= '0;
    end else if (cmd.stepEn) begin
      if (lastStep) begin
        freqWord  <= targetLatched;
        remaining <= '0;
      end else begin
        freqWord  <= dirDown ? (freqWord - stepSize) : (freqWord + stepSize);
        remaining <= remaining - stepSize;
      end
    end
  end
endmodule

// File: rtl/rampCtrl.sv
module rampCtrl
  import rampPkg::*;
#(
  parameter int IVL_CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  bypass,
  input  logic [IVL_CODE_W-1:0] ivlCode,
  input  logic                  zeroDiff,
  input  logic                  lastStep,
  output rampCmdT               cmd,
  output logic                  busy,
  output logic                  done
);
  localparam int CNT_W = 1 << IVL_CODE_W;

  rampStateT             state, nextState;
  logic [IVL_CODE_W-1:0] ivlCodeReg;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      ivlLast;
  logic                  doneNext;
  logic                  tick;

  assign ivlLast = ({{(CNT_W-1){1'b0}}, 1'b1} << ivlCodeReg) - {{(CNT_W-1){1'b0}}, 1'b1};
  assign tick    = (cnt == ivlLast);

  always_comb begin
    cmd       = '0;
    doneNext  = 1'b0;
    nextState = state;
    if (start) begin
      if (bypass || zeroDiff) begin
        cmd.jump  = 1'b1;
        doneNext  = 1'b1;
        nextState = ST_IDLE;
      end else begin
        cmd.load  = 1'b1;
        nextState = ST_RAMP;
      end
    end else if (state == ST_RAMP && tick) begin
      cmd.stepEn = 1'b1;
      if (lastStep) begin
        doneNext  = 1'b1;
        nextState = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      cnt        <= '0;
      ivlCodeReg <= '0;
    end else begin
      state <= nextState;
      done  <= doneNext;
      if (cmd.load) begin
        cnt        <= '0;
        ivlCodeReg <= ivlCode;
      end else if (state == ST_RAMP) begin
        cnt <= tick ? '0 : cnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_RAMP);
endmodule

// File: rtl/holdoverRampGen.sv
module holdoverRampGen
  import rampPkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int STEP_CODE_W = 3,
  parameter int STEP_SHIFT  = 2,
  parameter int IVL_CODE_W  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [WORD_W-1:0]      holdWord,
  input  logic [WORD_W-1:0]      targetWord,
  input  logic [STEP_CODE_W-1:0] stepCode,
  input  logic [IVL_CODE_W-1:0]  ivlCode,
  input  logic                   bypass,
  output logic [WORD_W-1:0]      freqWord,
  output logic                   busy,
  output logic                   done
);
  rampCmdT           cmd;
  logic              zeroDiff;
  logic              lastStep;
  logic              dirDown;
  logic [WORD_W-1:0] targetLatched;

  rampCtrl #(.IVL_CODE_W(IVL_CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bypass(bypass),
    .ivlCode(ivlCode), .zeroDiff(zeroDiff), .lastStep(lastStep),
    .cmd(cmd), .busy(busy), .done(done)
  );

  rampDatapath #(
    .WORD_W(WORD_W), .STEP_CODE_W(STEP_CODE_W), .STEP_SHIFT(STEP_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .holdWord(holdWord),
    .targetWord(targetWord), .stepCode(stepCode), .freqWord(freqWord),
    .targetLatched(targetLatched), .dirDown(dirDown),
    .zeroDiff(zeroDiff), .lastStep(lastStep)
  );
endmodule

// File: rtl/holdoverRampGenChecker.sv
module holdoverRampGenChecker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              bypass,
  input logic [WORD_W-1:0] holdWord,
  input logic [WORD_W-1:0] targetWord,
  input logic [WORD_W-1:0] freqWord,
  input logic [WORD_W-1:0] targetLatched,
  input logic              dirDown,
  input logic              busy,
  input logic              done
);
  // R2: a ramp start loads the holdover word and raises busy
  p_load_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !bypass && holdWord != targetWord) |=> (busy && freqWord == $past(holdWord)));

  // R4: an upward ramp never passes its target
  p_no_overshoot_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !dirDown) |-> (freqWord <= targetLatched));

  // R4: a downward ramp never passes its target
  p_no_overshoot_dn_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dirDown) |-> (freqWord >= targetLatched));

  // R5: done and busy never overlap
  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: done lasts one cycle unless a new start arrives
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  // R6: bypass jumps straight to the target
  p_bypass_jump_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && bypass) |=> (freqWord == $past(targetWord) && done && !busy));

  // R9: idle word is held without a start
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(freqWord));
endmodule

bind holdoverRampGen holdoverRampGenChecker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .bypass(bypass),
  .holdWord(holdWord), .targetWord(targetWord), .freqWord(freqWord),
  .targetLatched(targetLatched), .dirDown(dirDown),
  .busy(busy), .done(done)
);

// File: tb/holdoverRampGen_tb.sv
module holdoverRampGen_tb;
  localparam int WORD_W = 24;
  localparam longint WMAX = (64'd1 << WORD_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [WORD_W-1:0] holdWord = '0;
  logic [WORD_W-1:0] targetWord = '0;
  logic [2:0]        stepCode = '0;
  logic [2:0]        ivlCode = '0;
  logic              bypass = 1'b0;
  logic [WORD_W-1:0] freqWord;
  logic              busy;
  logic              done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  holdoverRampGen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .holdWord(holdWord),
    .targetWord(targetWord), .stepCode(stepCode), .ivlCode(ivlCode),
    .bypass(bypass), .freqWord(freqWord), .busy(busy), .done(done)
  );

  task automatic check(input string req, input longint expW, input bit expB, input bit expD);
    compared++;
    if (longint'(freqWord) != expW || busy != expB || done != expD) begin
      mismatched++;
      $display("FAIL %s: word=%0d busy=%0b done=%0b expected word=%0d busy=%0b done=%0b",
               req, freqWord, busy, done, expW, expB, expD);
    end
  endtask

  // Runs a ramp; checks each cycle. stopAfter>0 leaves early (for restart tests).
  task automatic runRamp(input longint h, input longint t, input int sc, input int ic,
                         input string req, input int stopAfter);
    longint step = 64'd1 << (2 * sc);
    longint ivl = 64'd1 << ic;
    longint mag = (t > h) ? t - h : h - t;
    longint nSteps = (mag + step - 1) / step;
    longint endM = nSteps * ivl;
    @(negedge clk);
    holdWord = h[WORD_W-1:0]; targetWord = t[WORD_W-1:0];
    stepCode = 3'(sc); ivlCode = 3'(ic); bypass = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble codes after start; captured values must be used
    stepCode = ~stepCode; ivlCode = ~ivlCode;
    if (mag == 0) begin
      check({"R7 ", req}, t, 1'b0, 1'b1);
    end else begin
      for (longint m = 0; m <= endM; m++) begin
        longint moved = (m / ivl) * step;
        longint expW;
        if (moved > mag) moved = mag;
        expW = (t > h) ? h + moved : h - moved;
        if (m == 0)         check({"R2 ", req}, expW, 1'b1, 1'b0);
        else if (m == endM) check({"R4 R5 ", req}, expW, 1'b0, 1'b1);
        else                check({"R3 R10 ", req}, expW, 1'b1, 1'b0);
        if (stopAfter > 0 && m == longint'(stopAfter)) return;
        if (m != endM) @(negedge clk);
      end
    end
    @(negedge clk);
    check({"R5 after ", req}, t, 1'b0, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        mismatched++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    longint diffs[7] = '{300, -300, 37, -37, 1, 16, 0};
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 0, 1'b0, 1'b0);

    // Sweep step and interval codes over both directions and boundary sizes
    for (int sc = 0; sc < 8; sc++)
      for (int ic = 0; ic < 4; ic++)
        for (int d = 0; d < 7; d++)
          runRamp(1000000, 1000000 + diffs[d], sc, ic, "sweep", 0);

    // Range ends
    runRamp(5, 0, 1, 1, "low end down", 0);
    runRamp(WMAX - 9, WMAX, 1, 0, "high end up", 0);
    runRamp(WMAX, 0, 7, 0, "full span down", 0);

    // R6: bypass jump
    @(negedge clk);
    holdWord = 24'd100; targetWord = 24'd9000; bypass = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; bypass = 1'b0;
    check("R6 bypass jump", 9000, 1'b0, 1'b1);
    @(negedge clk);
    check("R6 bypass after", 9000, 1'b0, 1'b0);

    // R8: restart mid-ramp
    runRamp(2000, 2500, 0, 1, "R8 first", 20);
    runRamp(7000, 6000, 2, 2, "R8 restart", 0);

    // R9: idle inputs ignored
    @(negedge clk);
    holdWord = 24'd1; targetWord = 24'd2; stepCode = 3'd5; ivlCode = 3'd2;
    repeat (5) @(negedge clk);
    check("R9 idle hold", 6000, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule